// File: doc/BRIEF.md
# Clock Spreading Stage Gate

This block is one output stage of a clock generation unit. On every cycle of its base clock it decides whether the module it feeds may receive a clock pulse. It delivers that decision as a registered clock-enable strobe aligned to the base clock, and never gates the clock itself. Module flops qualify their updates with this strobe.

The decision combines several inputs. A software enable bit can turn the stage off. Depending on build parameters, two further qualifiers may apply: an access-enable input, so that static peripheral registers tick only while the processor is reaching them, and a strobe from an external fractional divider. Each stage also has a wakeup-select bit. Stages with that bit set are governed by a global wakeup request, under the control of a two-bit power-mode register.

Software writes the stage configuration and the power mode through plain write-enable and data ports. The divider and the clock source selection live elsewhere.

Top module: `clkstage_gate`

## Requirements
- R1: While `rst` is high on a rising edge, the next value of `clk_en_o` is 0.
- R2: Reset sets the enable bit to 1, the wakeup-select bit to 0 and the power mode to 01. With the access and divider qualifiers high, `clk_en_o` is therefore 1 on the first cycle after reset.
- R3: With the enable bit at 0, `clk_en_o` stays 0, unless the stage is wakeup-selected and the power mode is 11.
- R4: When built with `HAS_ACCESS_EN=1`, `clk_en_o` is 0 in any cycle following an edge at which `access_en_i` was 0. When built with `HAS_ACCESS_EN=0`, `access_en_i` has no effect on `clk_en_o`.
- R5: When built with `HAS_FDIV=1`, `clk_en_o` is 0 in any cycle following an edge at which `fdiv_strobe_i` was 0. When built with `HAS_FDIV=0`, the strobe has no effect on `clk_en_o`.
- R6: In power mode 11 (sleep), a wakeup-selected stage is gated by `wakeup_i` in place of its enable bit.
- R7: In power modes 00, 01 and 10, `wakeup_i` has no effect, and every stage follows its enable bit.
- R8: A stage whose wakeup-select bit is 0 follows its enable bit in every power mode, whatever the value of `wakeup_i`.
- R9: `clk_en_o` is a register. Its value after an edge is the AND of the qualifiers sampled at that edge.
- R10: Configuration writes take effect one cycle later. On a write, `cfg_wdata` bit 0 is the enable bit and bit 1 is the wakeup-select bit, and `pmode_wdata` holds the mode. The output after the write edge still reflects the old settings, and the output after the following edge reflects the new ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the stage configuration |
| cfg_wdata | input | 2 | Bit 0 is the enable bit; bit 1 is the wakeup-select bit |
| pmode_we | input | 1 | Write strobe for the power mode |
| pmode_wdata | input | 2 | New power mode (11 is sleep) |
| access_en_i | input | 1 | Access qualifier (used when HAS_ACCESS_EN=1) |
| fdiv_strobe_i | input | 1 | Fractional-divider strobe (used when HAS_FDIV=1) |
| wakeup_i | input | 1 | Global wakeup request |
| clk_en_o | output | 1 | Registered clock-enable strobe |

## Verification
The bench sweeps every combination of enable bit, wakeup-select bit, power mode, access input, divider strobe and wakeup. It runs the sweep on a fully qualified build and on a build without the optional qualifiers. This exposes two faults:
- A gate that lets wakeup override the enable bit in the wrong modes, which would clock sleeping or disabled modules.
- A gate that treats modes 00 or 10 as sleep, which would stall wakeup-selected stages.

Each write is followed cycle by cycle. A design that applied the new settings at the write edge would emit a pulse one cycle early, or drop one. A reset in the middle of the run confirms that the register defaults return. A wrong power-mode default would leave wakeup-selected stages stopped after reset.

// File: rtl/clkstage_pkg.sv
package clkstage_pkg;
  localparam int PMODE_W = 2;
  localparam int CFG_W   = 2;

  typedef enum logic [PMODE_W-1:0] {
    PM_LOW0  = 2'b00,
    PM_RUN   = 2'b01,
    PM_LOW2  = 2'b10,
    PM_SLEEP = 2'b11
  } pmode_e;

  localparam int CFG_EN_BIT   = 0;
  localparam int CFG_WSEL_BIT = 1;
endpackage

// File: rtl/clkstage_cfg_reg.sv
module clkstage_cfg_reg
  import clkstage_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic             stage_en,
  output logic             stage_wsel
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stage_en   <= 1'b1;
      stage_wsel <= 1'b0;
    end else if (we) begin
      stage_en   <= wdata[CFG_EN_BIT];
      stage_wsel <= wdata[CFG_WSEL_BIT];
    end
  end
endmodule

// File: rtl/clkstage_pmode_reg.sv
module clkstage_pmode_reg
  import clkstage_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [PMODE_W-1:0] wdata,
  output pmode_e             pmode
);
  always_ff @(posedge clk) begin
    if (rst)     pmode <= PM_RUN;
    else if (we) pmode <= pmode_e'(wdata);
  end
endmodule

// File: rtl/clkstage_qualify.sv
module clkstage_qualify
  import clkstage_pkg::*;
#(
  parameter bit HAS_ACCESS_EN = 1'b1,
  parameter bit HAS_FDIV      = 1'b1
) (
  input  logic   stage_en,
  input  logic   stage_wsel,
  input  pmode_e pmode,
  input  logic   access_en_i,
  input  logic   fdiv_strobe_i,
  input  logic   wakeup_i,
  output logic   allow
);
  logic base_ok;
  logic acc_ok;
  logic div_ok;

  // Sleep hands wakeup-selected stages over to the wakeup request.
  always_comb begin
    if (stage_wsel && (pmode == PM_SLEEP)) base_ok = wakeup_i;
    else                                   base_ok = stage_en;
  end

  generate
    if (HAS_ACCESS_EN) begin : g_acc
      assign acc_ok = access_en_i;
    end else begin : g_no_acc
      logic unused_acc;
      assign unused_acc = access_en_i;
      assign acc_ok     = 1'b1;
    end
    if (HAS_FDIV) begin : g_div
      assign div_ok = fdiv_strobe_i;
    end else begin : g_no_div
      logic unused_div;
      assign unused_div = fdiv_strobe_i;
      assign div_ok     = 1'b1;
    end
  endgenerate

  assign allow = base_ok & acc_ok & div_ok;
endmodule

// File: rtl/clkstage_gate.sv
module clkstage_gate
  import clkstage_pkg::*;
#(
  parameter bit HAS_ACCESS_EN = 1'b1,
  parameter bit HAS_FDIV      = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [CFG_W-1:0]   cfg_wdata,
  input  logic               pmode_we,
  input  logic [PMODE_W-1:0] pmode_wdata,
  input  logic               access_en_i,
  input  logic               fdiv_strobe_i,
  input  logic               wakeup_i,
  output logic               clk_en_o
);
  logic   stage_en;
  logic   stage_wsel;
  pmode_e pmode_q;
  logic   allow;

  clkstage_cfg_reg u_cfg (
    .clk        (clk),
    .rst        (rst),
    .we         (cfg_we),
    .wdata      (cfg_wdata),
    .stage_en   (stage_en),
    .stage_wsel (stage_wsel)
  );

  clkstage_pmode_reg u_pmode (
    .clk   (clk),
    .rst   (rst),
    .we    (pmode_we),
    .wdata (pmode_wdata),
    .pmode (pmode_q)
  );

  clkstage_qualify #(
    .HAS_ACCESS_EN (HAS_ACCESS_EN),
    .HAS_FDIV      (HAS_FDIV)
  ) u_qual (
    .stage_en      (stage_en),
    .stage_wsel    (stage_wsel),
    .pmode         (pmode_q),
    .access_en_i   (access_en_i),
    .fdiv_strobe_i (fdiv_strobe_i),
    .wakeup_i      (wakeup_i),
    .allow         (allow)
  );

  // Registered strobe: glitch-free and whole-cycle.
  always_ff @(posedge clk) begin
    if (rst) clk_en_o <= 1'b0;
    else     clk_en_o <= allow;
  end
endmodule

// File: rtl/clkstage_gate_chk.sv
module clkstage_gate_chk
  import clkstage_pkg::*;
#(
  parameter bit HAS_ACCESS_EN = 1'b1,
  parameter bit HAS_FDIV      = 1'b1
) (
  input logic   clk,
  input logic   rst,
  input logic   access_en_i,
  input logic   fdiv_strobe_i,
  input logic   wakeup_i,
  input logic   st_en,
  input logic   st_wsel,
  input pmode_e pmode,
  input logic   clk_en_o
);
  assert_reset_defaults_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (st_en && !st_wsel && pmode == PM_RUN));

  assert_enable_off_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(st_en) && !($past(st_wsel) && $past(pmode) == PM_SLEEP))
      |-> !clk_en_o);

  assert_sleep_wake_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(st_wsel) && $past(pmode) == PM_SLEEP && !$past(wakeup_i))
      |-> !clk_en_o);

  assert_out_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !clk_en_o);

  generate
    if (HAS_ACCESS_EN) begin : g_acc
      assert_access_gate_R4: assert property (@(posedge clk) disable iff (rst)
        !$past(access_en_i) |-> !clk_en_o);
    end else begin : g_no_acc
      logic unused_acc;
      assign unused_acc = access_en_i;
    end
    if (HAS_FDIV) begin : g_div
      assert_fdiv_gate_R5: assert property (@(posedge clk) disable iff (rst)
        !$past(fdiv_strobe_i) |-> !clk_en_o);
    end else begin : g_no_div
      logic unused_div;
      assign unused_div = fdiv_strobe_i;
    end
  endgenerate
endmodule

bind clkstage_gate clkstage_gate_chk #(
  .HAS_ACCESS_EN (HAS_ACCESS_EN),
  .HAS_FDIV      (HAS_FDIV)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .access_en_i   (access_en_i),
  .fdiv_strobe_i (fdiv_strobe_i),
  .wakeup_i      (wakeup_i),
  .st_en         (stage_en),
  .st_wsel       (stage_wsel),
  .pmode         (pmode_q),
  .clk_en_o      (clk_en_o)
);

// File: tb/clkstage_gate_bench.sv
module clkstage_gate_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_wdata = 2'b00;
  logic       pmode_we = 1'b0;
  logic [1:0] pmode_wdata = 2'b00;
  logic       acc = 1'b0;
  logic       fdv = 1'b0;
  logic       wk = 1'b0;
  logic       out_full;
  logic       out_plain;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // model state
  logic       m_en = 1'b1;
  logic       m_ws = 1'b0;
  logic [1:0] m_pm = 2'b01;

  always #10 clk = ~clk;  // 50 MHz

  clkstage_gate #(.HAS_ACCESS_EN(1'b1), .HAS_FDIV(1'b1)) u_clkstage_gate (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .pmode_we(pmode_we), .pmode_wdata(pmode_wdata), .access_en_i(acc),
    .fdiv_strobe_i(fdv), .wakeup_i(wk), .clk_en_o(out_full));

  clkstage_gate #(.HAS_ACCESS_EN(1'b0), .HAS_FDIV(1'b0)) u_clkstage_gate_plain (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .pmode_we(pmode_we), .pmode_wdata(pmode_wdata), .access_en_i(acc),
    .fdiv_strobe_i(fdv), .wakeup_i(wk), .clk_en_o(out_plain));

  function automatic logic expect_out(logic full);
    logic base;
    if (rst) return 1'b0;                        // R1
    base = (m_ws && m_pm == 2'b11) ? wk : m_en;  // R3 R6 R7 R8
    if (full) return base & acc & fdv;           // R4 R5
    return base;
  endfunction

  function automatic string tag_of(logic full);
    if (rst) return "R1";
    if (m_ws && m_pm == 2'b11) return "R6";
    if (!m_en) return "R3";
    if (full && !(acc && fdv)) return full && !acc ? "R4" : "R5";
    if (m_ws) return "R7";
    return "R8";
  endfunction

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: clk_en_o actual=%0b expected=%0b (en=%0b ws=%0b pm=%0b acc=%0b fdv=%0b wk=%0b)",
               tag, act, exp, m_en, m_ws, m_pm, acc, fdv, wk);
    end
  endtask

  // Called at a falling edge with inputs already set; runs one cycle.
  task automatic tick();
    logic e_full, e_plain;
    string t_full, t_plain;
    e_full  = expect_out(1'b1);
    e_plain = expect_out(1'b0);
    t_full  = tag_of(1'b1);
    t_plain = tag_of(1'b0);
    @(posedge clk);
    if (rst) begin
      m_en = 1'b1; m_ws = 1'b0; m_pm = 2'b01;
    end else begin
      if (cfg_we) begin m_en = cfg_wdata[0]; m_ws = cfg_wdata[1]; end  // R10
      if (pmode_we) m_pm = pmode_wdata;
    end
    @(negedge clk);
    check({t_full, "/R9 full"}, out_full, e_full);
    check({t_plain, "/R9 plain"}, out_plain, e_plain);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    rst = 1'b1; acc = 1'b1; fdv = 1'b1;
    for (int k = 0; k < 3; k++) tick();  // R1
    rst = 1'b0;
    tick();  // R2: defaults enable the stage
    check("R2 default pulse", out_full, 1'b1);

    // exhaustive sweep: config written, then one cycle with the new config
    for (int i = 0; i < 128; i++) begin
      cfg_we = 1'b1; cfg_wdata = i[1:0];
      pmode_we = 1'b1; pmode_wdata = i[3:2];
      acc = i[4]; fdv = i[5]; wk = i[6];
      tick();  // R10: old config still applies this cycle
      cfg_we = 1'b0; pmode_we = 1'b0;
      tick();
      wk = ~wk;
      tick();
      acc = ~acc;
      tick();
    end

    // R10: write-latency sequence
    acc = 1'b1; fdv = 1'b1; wk = 1'b0;
    cfg_we = 1'b1; cfg_wdata = 2'b01; pmode_we = 1'b1; pmode_wdata = 2'b01;
    tick();
    cfg_wdata = 2'b00; pmode_we = 1'b0;
    tick();
    check("R10 old value held after write edge", out_full, 1'b1);
    cfg_we = 1'b0;
    tick();
    check("R10 new value after next edge", out_full, 1'b0);

    // mid-run reset restores defaults (R2)
    cfg_we = 1'b1; cfg_wdata = 2'b10; pmode_we = 1'b1; pmode_wdata = 2'b11;
    tick();
    cfg_we = 1'b0; pmode_we = 1'b0; wk = 1'b0;
    tick();
    check("R6 sleeping stage without wakeup", out_full, 1'b0);
    rst = 1'b1;
    tick();
    rst = 1'b0;
    tick();
    tick();
    check("R2 defaults after mid-run reset", out_full, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule